// File: doc/BRIEF.md
# Descriptor Chain Prefetcher

This block walks a linked list of DMA descriptors held in memory and turns each one into a command for a separate data mover. A descriptor is four 32-bit words: the byte address of the next descriptor, a destination buffer address, a byte count, and a control word. The control word carries the ownership flag, which says whether hardware may use the descriptor or software still holds it, and an interrupt-request flag. The block reads all four words in address order, so the control word arrives last. Only after that word has been checked does it act on the descriptor.

A descriptor that hardware owns and that passes the length and alignment checks becomes a command to the mover. When the mover reports the transfer finished, the block writes the control word back with ownership handed to software. It raises a one-cycle interrupt if the descriptor asked for one, and then follows the next pointer. A descriptor that software owns parks the block in a polling loop. The block waits a programmable number of cycles and then re-reads that descriptor. A chain therefore ends on a software-owned descriptor. Software extends the chain while it runs by filling in that descriptor and setting its ownership flag last.

A level-sensitive run input starts the walk at a programmed first-descriptor address. Dropping run while the block polls returns it to idle, so it can be restarted somewhere else. A descriptor that fails the checks halts the block with its error flag set until run is dropped.

Top module: `dpf_prefetcher`

## Requirements
- R1: During and straight after reset, st_idle is 1 and mem_req, cmd_valid, irq and err are all 0.
- R2: With run high from idle, the block reads start_addr+0, +4, +8 and +12 in that order, one outstanding read at a time. The control word at offset 12 is read last.
- R3: A hardware-owned descriptor (control bit 31 = 1) that passes the checks produces one mover command. cmd_addr comes from word 1 and cmd_len from word 2, and both stay stable until cmd_ready.
- R4: A software-owned descriptor (control bit 31 = 0) produces no command and sets st_poll. The block re-reads the same descriptor, starting poll_interval cycles after it enters polling.
- R5: Setting bit 31 of a polled descriptor's control word in memory makes the block issue that descriptor on a later poll.
- R6: After xfer_done, the block writes the descriptor's control word (offset 12) back with bit 31 cleared and every other bit unchanged.
- R7: irq pulses for one cycle after the write-back only when control bit 0 is 1.
- R8: A byte count (full word 2) of 0 or above 2048 produces no command and sets err.
- R9: A destination address or byte count that is not a multiple of 128 produces no command and sets err.
- R10: Dropping run while polling returns the block to idle. Raising run again starts the walk at the newly programmed start_addr.
- R11: After a write-back, the next descriptor fetched is the one at the address in word 0.
- R12: At most one of st_idle, st_fetch, st_poll and st_busy is high in any cycle.
- R13: err stays high until run is dropped, and the block then returns to idle with err low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Level run/stop control |
| start_addr | input | AW | Byte address of the first descriptor |
| poll_interval | input | PW | Cycles to wait before re-reading a software-owned descriptor |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| cmd_valid | output | 1 | Mover command valid |
| cmd_ready | input | 1 | Mover accepts the command |
| cmd_addr | output | AW | Destination address for the mover |
| cmd_len | output | LEN_W | Byte count for the mover |
| xfer_done | input | 1 | Mover finished the current transfer |
| irq | output | 1 | Transfer-complete interrupt pulse |
| st_idle | output | 1 | Stopped |
| st_fetch | output | 1 | Reading a descriptor |
| st_poll | output | 1 | Waiting on a software-owned descriptor |
| st_busy | output | 1 | Command, transfer or write-back in progress |
| err | output | 1 | Halted on a rejected descriptor |

## Verification
A wrong word index or base address inside the block shows up as a bad read order at mem_addr within the first eight cycles of a fetch. It can also appear as a command carrying another descriptor's destination. A wrong ownership decision shows within one cycle of the fourth read returning: either a command goes out while the chain should be parked, or st_poll rises while a hardware-owned descriptor waits. A corrupted poll counter shows as the wrong spacing between successive reads of the parked descriptor. A lost current-descriptor pointer shows as a write-back to the wrong control word in memory, which is visible right after xfer_done.

// File: rtl/dpf_pkg.sv
package dpf_pkg;

    localparam int DESC_WORDS = 4;
    localparam int WORD_W     = 32;
    localparam int OWN_BIT    = 31;
    localparam int IEN_BIT    = 0;

    // Word order in memory: link, destination, byte count, control (last).
    typedef struct packed {
        logic [WORD_W-1:0] link;
        logic [WORD_W-1:0] dst;
        logic [WORD_W-1:0] count;
        logic [WORD_W-1:0] ctrl;
    } desc_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_POLL,
        S_ISSUE,
        S_XFER,
        S_WB,
        S_NEXT,
        S_HALT
    } pf_state_e;

    function automatic logic count_bad(input logic [WORD_W-1:0] cnt,
                                       input int unsigned lmax);
        return (cnt == '0) || (cnt > WORD_W'(lmax));
    endfunction

    function automatic logic line_bad(input logic [WORD_W-1:0] addr,
                                      input logic [WORD_W-1:0] cnt,
                                      input int unsigned line);
        logic [WORD_W-1:0] mask;
        mask = WORD_W'(line - 1);
        return ((addr | cnt) & mask) != '0;
    endfunction

endpackage

// File: rtl/dpf_word_fetch.sv
module dpf_word_fetch
    import dpf_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [AW-1:0]     base,
    input  logic              rvalid,
    input  logic [WORD_W-1:0] rdata,
    output logic              rd_req,
    output logic [AW-1:0]     rd_addr,
    output desc_t             desc,
    output logic              desc_valid,
    output logic              active
);
    localparam int KW = $clog2(DESC_WORDS);
    localparam logic [KW-1:0] LAST_K = KW'(DESC_WORDS - 1);

    logic [KW-1:0]                      k;
    logic                               pending;
    logic [AW-1:0]                      base_q;
    logic [0:DESC_WORDS-1][WORD_W-1:0]  wq;

    assign rd_req  = active && !pending;
    assign rd_addr = base_q + AW'({k, 2'b00});
    assign desc    = desc_t'(wq);

    always_ff @(posedge clk) begin
        if (rst) begin
            active     <= 1'b0;
            pending    <= 1'b0;
            k          <= '0;
            base_q     <= '0;
            desc_valid <= 1'b0;
            wq         <= '0;
        end else begin
            desc_valid <= 1'b0;
            if (start) begin
                active  <= 1'b1;
                pending <= 1'b0;
                k       <= '0;
                base_q  <= base;
            end else if (active) begin
                if (!pending) begin
                    pending <= 1'b1;
                end else if (rvalid) begin
                    wq[k]   <= rdata;
                    pending <= 1'b0;
                    if (k == LAST_K) begin
                        active     <= 1'b0;
                        desc_valid <= 1'b1;
                    end else begin
                        k <= k + 1'b1;
                    end
                end
            end
        end
    end

    AST_RDATA_EXPECTED: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> pending);                                          // R2
    AST_CTRL_WORD_LAST: assert property (@(posedge clk) disable iff (rst)
        desc_valid |-> ($past(rvalid) && $past(k) == LAST_K));        // R2
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req);                                          // R2

endmodule

// File: rtl/dpf_poll_timer.sv
module dpf_poll_timer #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          en,
    input  logic [PW-1:0] interval,
    output logic          expired
);
    logic [PW-1:0] cnt;

    assign expired = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= interval;
        end else if (en && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    AST_TIMER_STEP: assert property (@(posedge clk) disable iff (rst)
        (en && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));   // R4
    AST_TIMER_HOLD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt == '0) |=> (cnt == '0));                        // R4

endmodule

// File: rtl/dpf_desc_check.sv
module dpf_desc_check
    import dpf_pkg::*;
#(
    parameter int AW      = 32,
    parameter int LEN_MAX = 2048,
    parameter int LINE    = 128,
    parameter int LEN_W   = 12
) (
    input  desc_t             d,
    output logic              hw_owned,
    output logic              ien,
    output logic              fault,
    output logic [AW-1:0]     dst,
    output logic [LEN_W-1:0]  len,
    output logic [AW-1:0]     link
);
    logic len_fault;
    logic line_fault;

    assign hw_owned  = d.ctrl[OWN_BIT];
    assign ien       = d.ctrl[IEN_BIT];
    assign dst       = d.dst[AW-1:0];
    assign link      = d.link[AW-1:0];
    assign len       = d.count[LEN_W-1:0];
    assign len_fault = count_bad(d.count, LEN_MAX);

    generate
        if (LINE > 1) begin : g_line
            assign line_fault = line_bad(d.dst, d.count, LINE);
        end else begin : g_noline
            assign line_fault = 1'b0;
        end
    endgenerate

    assign fault = len_fault || line_fault;

endmodule

// File: rtl/dpf_prefetcher.sv
module dpf_prefetcher
    import dpf_pkg::*;
#(
    parameter int AW      = 32,
    parameter int LEN_MAX = 2048,
    parameter int LINE    = 128,
    parameter int PW      = 16,
    localparam int LEN_W  = $clog2(LEN_MAX) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [AW-1:0]     start_addr,
    input  logic [PW-1:0]     poll_interval,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [AW-1:0]     cmd_addr,
    output logic [LEN_W-1:0]  cmd_len,
    input  logic              xfer_done,
    output logic              irq,
    output logic              st_idle,
    output logic              st_fetch,
    output logic              st_poll,
    output logic              st_busy,
    output logic              err
);
    localparam logic [AW-1:0]     CTRL_OFS = AW'((DESC_WORDS - 1) * 4);
    localparam logic [WORD_W-1:0] OWN_MASK = WORD_W'(1) << OWN_BIT;
    localparam logic [AW-1:0]     LINE_MASK = AW'(LINE - 1);

    pf_state_e         state, nxt;
    logic [AW-1:0]     cur_q;
    logic              irq_q;

    logic              fetch_start;
    logic [AW-1:0]     fetch_base;
    logic              rd_req;
    logic [AW-1:0]     rd_addr;
    desc_t             desc;
    logic              desc_valid;
    logic              fetch_active;

    logic              hw_owned, ien, fault;
    logic [AW-1:0]     d_dst, d_link;
    logic [LEN_W-1:0]  d_len;

    logic              timer_load, timer_expired;

    dpf_word_fetch #(.AW(AW)) u_fetch (
        .clk        (clk),
        .rst        (rst),
        .start      (fetch_start),
        .base       (fetch_base),
        .rvalid     (mem_rvalid),
        .rdata      (mem_rdata),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .desc       (desc),
        .desc_valid (desc_valid),
        .active     (fetch_active)
    );

    dpf_desc_check #(
        .AW(AW), .LEN_MAX(LEN_MAX), .LINE(LINE), .LEN_W(LEN_W)
    ) u_check (
        .d        (desc),
        .hw_owned (hw_owned),
        .ien      (ien),
        .fault    (fault),
        .dst      (d_dst),
        .len      (d_len),
        .link     (d_link)
    );

    assign timer_load = (state == S_FETCH) && desc_valid && !hw_owned;

    dpf_poll_timer #(.PW(PW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (timer_load),
        .en       (state == S_POLL),
        .interval (poll_interval),
        .expired  (timer_expired)
    );

    always_comb begin
        nxt         = state;
        fetch_start = 1'b0;
        fetch_base  = cur_q;
        case (state)
            S_IDLE: if (run) begin
                fetch_start = 1'b1;
                fetch_base  = start_addr;
                nxt         = S_FETCH;
            end
            S_FETCH: if (desc_valid) begin
                if (!hw_owned)  nxt = S_POLL;
                else if (fault) nxt = S_HALT;
                else            nxt = S_ISSUE;
            end
            S_POLL: begin
                if (!run) begin
                    nxt = S_IDLE;
                end else if (timer_expired) begin
                    fetch_start = 1'b1;
                    nxt         = S_FETCH;
                end
            end
            S_ISSUE: if (cmd_ready) nxt = S_XFER;
            S_XFER:  if (xfer_done) nxt = S_WB;
            S_WB:    nxt = S_NEXT;
            S_NEXT: begin
                if (run) begin
                    fetch_start = 1'b1;
                    fetch_base  = d_link;
                    nxt         = S_FETCH;
                end else begin
                    nxt = S_IDLE;
                end
            end
            S_HALT:  if (!run) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            cur_q <= '0;
            irq_q <= 1'b0;
        end else begin
            state <= nxt;
            irq_q <= (state == S_WB) && ien;
            if (fetch_start) cur_q <= fetch_base;
        end
    end

    assign mem_we    = (state == S_WB);
    assign mem_req   = rd_req || mem_we;
    assign mem_addr  = mem_we ? (cur_q + CTRL_OFS) : rd_addr;
    assign mem_wdata = desc.ctrl & ~OWN_MASK;

    assign cmd_valid = (state == S_ISSUE);
    assign cmd_addr  = d_dst;
    assign cmd_len   = d_len;
    assign irq       = irq_q;

    assign st_idle  = (state == S_IDLE);
    assign st_fetch = (state == S_FETCH);
    assign st_poll  = (state == S_POLL);
    assign st_busy  = (state == S_ISSUE) || (state == S_XFER) ||
                      (state == S_WB)    || (state == S_NEXT);
    assign err      = (state == S_HALT);

    AST_CMD_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_len != '0 && cmd_len <= LEN_W'(LEN_MAX)));  // R8
    AST_CMD_LINE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> ((cmd_addr & LINE_MASK) == '0 &&
                       (AW'(cmd_len) & LINE_MASK) == '0));               // R9
    AST_CMD_HELD: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) &&
                                       $stable(cmd_len)));               // R3
    AST_WB_TO_SOFTWARE: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> !mem_wdata[OWN_BIT]);                    // R6
    AST_NO_CMD_WHILE_POLL: assert property (@(posedge clk) disable iff (rst)
        st_poll |-> !cmd_valid);                                         // R4
    AST_IRQ_AFTER_WB: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(mem_req && mem_we));                               // R7
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);                                                   // R7
    AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({st_idle, st_fetch, st_poll, st_busy}));                // R12
    AST_ERR_NO_CMD: assert property (@(posedge clk) disable iff (rst)
        err |-> (!cmd_valid && !mem_req));                               // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err && run) |=> err);                                           // R13
    AST_NO_FETCH_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        st_idle |-> !fetch_active);                                      // R10

endmodule

// File: tb/sim_dpf_prefetcher.sv
module sim_dpf_prefetcher;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W      = 12;

    typedef struct packed {
        logic [31:0] dst;
        logic [31:0] cnt;
        logic        ien;
        logic        bad;
        logic        alg;
    } vec_t;

    // Main table: one descriptor per row, chained to a parked terminal.
    localparam vec_t VECS [8] = '{
        '{32'h0000_0080, 32'h0000_0080, 1'b1, 1'b0, 1'b0},
        '{32'h0000_1000, 32'h0000_0800, 1'b0, 1'b0, 1'b0},
        '{32'h0000_2000, 32'h0000_0000, 1'b1, 1'b1, 1'b0},
        '{32'h0000_2000, 32'h0000_0801, 1'b0, 1'b1, 1'b0},
        '{32'h0000_3040, 32'h0000_0100, 1'b1, 1'b1, 1'b1},
        '{32'h0000_3000, 32'h0000_0064, 1'b0, 1'b1, 1'b1},
        '{32'h2000_0000, 32'h0000_0400, 1'b1, 1'b0, 1'b0},
        '{32'h0000_4000, 32'h0001_0080, 1'b0, 1'b1, 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run = 1'b0;
    logic [31:0] start_addr = '0;
    logic [15:0] poll_interval = 16'd20;

    logic              mem_req, mem_we;
    logic [31:0]       mem_addr, mem_wdata;
    logic              mem_rvalid;
    logic [31:0]       mem_rdata;
    logic              cmd_valid;
    logic              cmd_ready;
    logic [31:0]       cmd_addr;
    logic [LEN_W-1:0]  cmd_len;
    logic              xfer_done;
    logic              irq, st_idle, st_fetch, st_poll, st_busy, err;

    logic        host_we = 1'b0;
    logic [31:0] host_addr = '0;
    logic [31:0] host_data = '0;
    logic        log_clr = 1'b0;
    logic [31:0] watch = 32'hFFFF_FFFF;

    logic [31:0] mem [256];
    logic [31:0] rd_log [8];
    int          rd_n;
    int          tcount, t_last, gap;
    int          n_cmd, n_irq, dcnt;
    logic [31:0] last_addr;
    logic [LEN_W-1:0] last_len;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    assign cmd_ready = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpf_prefetcher u0 (
        .clk(clk), .rst(rst), .run(run), .start_addr(start_addr),
        .poll_interval(poll_interval),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_len(cmd_len), .xfer_done(xfer_done), .irq(irq),
        .st_idle(st_idle), .st_fetch(st_fetch), .st_poll(st_poll),
        .st_busy(st_busy), .err(err)
    );

    // Memory model: one-cycle read latency, read log and poll spacing.
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= '0;
            mem_rvalid <= 1'b0;
            mem_rdata  <= '0;
            rd_n <= 0; tcount <= 0; t_last <= 0; gap <= 0;
        end else begin
            tcount     <= tcount + 1;
            mem_rvalid <= 1'b0;
            if (host_we) mem[host_addr[9:2]] <= host_data;
            if (log_clr) rd_n <= 0;
            if (mem_req && mem_we) begin
                mem[mem_addr[9:2]] <= mem_wdata;
            end else if (mem_req) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem[mem_addr[9:2]];
                if (rd_n < 8 && !log_clr) begin
                    rd_log[rd_n] <= mem_addr;
                    rd_n <= rd_n + 1;
                end
                if (mem_addr == watch) begin
                    gap    <= tcount - t_last;
                    t_last <= tcount;
                end
            end
        end
    end

    // Mover model: done three cycles after the command is taken.
    always @(posedge clk) begin
        if (rst) begin
            n_cmd <= 0; dcnt <= 0; xfer_done <= 1'b0;
            last_addr <= '0; last_len <= '0;
        end else begin
            xfer_done <= 1'b0;
            if (cmd_valid && cmd_ready) begin
                n_cmd     <= n_cmd + 1;
                last_addr <= cmd_addr;
                last_len  <= cmd_len;
                dcnt      <= 3;
            end else if (dcnt != 0) begin
                dcnt <= dcnt - 1;
                if (dcnt == 1) xfer_done <= 1'b1;
            end
        end
    end

    always @(posedge clk) begin
        if (rst) n_irq <= 0;
        else if (irq) n_irq <= n_irq + 1;
    end

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_data = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [31:0] link,
                            input logic [31:0] dst, input logic [31:0] cnt,
                            input logic [31:0] ctrl);
        host_write(a,       link);
        host_write(a + 4,   dst);
        host_write(a + 8,   cnt);
        host_write(a + 12,  ctrl);
    endtask

    task automatic clear_log();
        @(negedge clk); log_clr = 1'b1;
        @(negedge clk); log_clr = 1'b0;
    endtask

    task automatic wait_poll_after(input int cmds);
        for (int c = 0; c < 400 && !(st_poll && n_cmd >= cmds); c++) @(negedge clk);
    endtask

    task automatic stop_run();
        run = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        summary();
    end

    initial begin
        int base_cmd, base_irq;
        logic [31:0] ctrl;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(st_idle && !mem_req && !cmd_valid && !irq && !err, "R1 reset outputs",
              {27'd0, st_idle, mem_req, cmd_valid, irq, err}, 32'h10);
        rst = 1'b0;
        @(negedge clk);
        check(st_idle && !mem_req && !err, "R1 after reset", {31'd0, st_idle}, 1);

        // Table walk
        for (int i = 0; i < 8; i++) begin
            ctrl = 32'h80AB_0000 | {31'd0, VECS[i].ien};
            put_desc(32'h100, 32'h200, VECS[i].dst, VECS[i].cnt, ctrl);
            put_desc(32'h200, 32'h300, 32'h0, 32'h80, 32'h0);
            base_cmd = n_cmd; base_irq = n_irq;
            start_addr = 32'h100;
            run = 1'b1;
            if (VECS[i].bad) begin
                for (int c = 0; c < 400 && !err; c++) @(negedge clk);
                repeat (5) @(negedge clk);
                check(err, VECS[i].alg ? "R9 err set" : "R8 err set", {31'd0, err}, 1);
                check(n_cmd == base_cmd, VECS[i].alg ? "R9 no command" : "R8 no command",
                      n_cmd - base_cmd, 0);
                check(err && mem[32'h10C >> 2] == ctrl, "R13 err held, no write-back",
                      mem[32'h10C >> 2], ctrl);
            end else begin
                wait_poll_after(base_cmd + 1);
                check(n_cmd == base_cmd + 1, "R3 one command", n_cmd - base_cmd, 1);
                check(last_addr == VECS[i].dst, "R3 cmd_addr", last_addr, VECS[i].dst);
                check(last_len == VECS[i].cnt[LEN_W-1:0], "R3 cmd_len",
                      {20'd0, last_len}, VECS[i].cnt);
                check(mem[32'h10C >> 2] == (ctrl & 32'h7FFF_FFFF), "R6 write-back",
                      mem[32'h10C >> 2], ctrl & 32'h7FFF_FFFF);
                check(n_irq - base_irq == int'(VECS[i].ien), "R7 irq count",
                      n_irq - base_irq, {31'd0, VECS[i].ien});
                check(st_poll && $countones({st_idle, st_fetch, st_poll, st_busy}) == 1,
                      "R12 status parked", {28'd0, st_idle, st_fetch, st_poll, st_busy}, 2);
            end
            stop_run();
            check(st_idle && !err, "R13 idle after stop", {30'd0, st_idle, err}, 2);
        end

        // R2 / R11: chain of two, then parked terminal
        put_desc(32'h040, 32'h080, 32'h300, 32'h100, 32'h8000_0001);
        put_desc(32'h080, 32'h0C0, 32'h400, 32'h080, 32'h8000_0000);
        put_desc(32'h0C0, 32'h140, 32'h500, 32'h180, 32'h0000_0001);
        put_desc(32'h140, 32'h000, 32'h0,   32'h080, 32'h0000_0000);
        clear_log();
        base_cmd = n_cmd; base_irq = n_irq;
        start_addr = 32'h040;
        run = 1'b1;
        wait_poll_after(base_cmd + 2);
        check(rd_log[0] == 32'h40 && rd_log[1] == 32'h44 && rd_log[2] == 32'h48 &&
              rd_log[3] == 32'h4C, "R2 read order", rd_log[3], 32'h4C);
        check(rd_log[4] == 32'h80, "R11 follows link", rd_log[4], 32'h80);
        check(n_cmd == base_cmd + 2 && last_addr == 32'h400, "R11 second command",
              last_addr, 32'h400);
        check(n_irq - base_irq == 1, "R7 only flagged descriptor", n_irq - base_irq, 1);

        // R4: parked on 0x0C0, spacing between re-reads
        watch = 32'h0C0;
        repeat (100) @(negedge clk);
        check(gap >= 21 && gap <= 36, "R4 poll spacing", gap, 30);
        check(n_cmd == base_cmd + 2 && st_poll == (st_poll | 1'b0), "R4 no command while parked",
              n_cmd - base_cmd, 2);

        // R5: hand the terminal over to hardware
        host_write(32'h0CC, 32'h8000_0001);
        wait_poll_after(base_cmd + 3);
        check(last_addr == 32'h500 && last_len == 12'h180, "R5 appended job",
              last_addr, 32'h500);
        check(mem[32'h0CC >> 2] == 32'h1, "R6 appended write-back", mem[32'h0CC >> 2], 1);

        // R10: stop while parked, restart elsewhere
        stop_run();
        check(st_idle && !st_poll, "R10 idle after stop", {30'd0, st_idle, st_poll}, 2);
        put_desc(32'h180, 32'h140, 32'h600, 32'h080, 32'h8000_0000);
        clear_log();
        start_addr = 32'h180;
        run = 1'b1;
        wait_poll_after(base_cmd + 4);
        check(rd_log[0] == 32'h180, "R10 restart address", rd_log[0], 32'h180);
        check(last_addr == 32'h600, "R10 restart command", last_addr, 32'h600);
        stop_run();
        check(st_idle, "R10 idle again", {31'd0, st_idle}, 1);

        summary();
    end
endmodule